// File: doc/BRIEF.md
# Over-Current Hiccup Retry Controller

This block sequences the protection of a linear regulator output when its load draws too much current. A comparator elsewhere raises a flag when the sensed current passes the limit threshold. The flag is resynchronised inside the block. The controller then keeps the regulator on with current limiting engaged for a short window. If the flag is still high when that window closes, the regulator is switched off for a much longer rest window. After the rest window it is switched back on and limited again. This hiccup cycle repeats for as long as the fault is still present at each check. The first check that finds the flag low returns the regulator to normal service.

Time is measured in pulses of a one-millisecond tick. The limit window and the rest window are parameters counted in those ticks. A single shutdown input, driven by whatever coordinates the neighbouring supply, overrides everything. It turns the regulator off and parks the controller until it is released.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While `rst` is high and on the first edge after it, the outputs are `reg_enable`=1, `limit_active`=0 and `fault`=0.
- R2: `oc_raw` passes through two flip-flops before use. A rise of `oc_raw` that is held shows up as `limit_active`=1, `fault`=1 and `reg_enable`=1 on the third rising edge after the change.
- R3: The limit window lasts exactly LIMIT_MS ticks. It ends on the edge that samples its LIMIT_MS-th `tick_ms` pulse after entry.
- R4: If the synchronised flag is high when the limit window ends, the outputs change on that edge to `reg_enable`=0, `limit_active`=0 and `fault`=1.
- R5: The rest window lasts exactly RETRY_MS ticks. On the edge that samples its last tick, the controller re-enters the limit window with `reg_enable`=1 and `limit_active`=1.
- R6: If the synchronised flag is low when a limit window ends, the controller returns to normal. The outputs become `reg_enable`=1, `limit_active`=0 and `fault`=0.
- R7: The limit/rest cycle repeats without bound while the flag is high at every end-of-limit check.
- R8: `shutdown` high at an edge forces `reg_enable`=0, `limit_active`=0 and `fault`=0 from that edge on. `oc_raw` has no effect while it is held. The first edge that samples it low returns the block to normal with `reg_enable`=1.
- R9: `tick_ms` pulses have no effect in normal operation. They do not change the outputs and do not shorten a later limit window.
- R10: `limit_active` is never high while `reg_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| oc_raw | input | 1 | Asynchronous over-current comparator flag |
| shutdown | input | 1 | External force-off request |
| limit_active | output | 1 | Current limiting engaged |
| reg_enable | output | 1 | Regulator enable |
| fault | output | 1 | Over-current fault in progress |

## Verification
The bench builds the block with LIMIT_MS=3 and RETRY_MS=5 and drives the tick on every cycle in the directed part. Whole limit/rest hiccup cycles therefore take only a few cycles. Several back-to-back cycles fit in a short run, and the exact window edges can be counted cycle by cycle. In the random part the tick rate, the flag and shutdown pulses vary while a behavioural model tracks the expected outputs. This exercises mid-window flag changes and shutdown arriving in each state.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIMIT = 2'd1,
    ST_OFF   = 2'd2,
    ST_HALT  = 2'd3
  } ocp_state_t;
endpackage

// File: rtl/ocp_sync2.sv
module ocp_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d_in;
      stab_q <= meta_q;
    end
  end

  assign d_out = stab_q;
endmodule

// File: rtl/ocp_interval_timer.sv
module ocp_interval_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = run && tick && (cnt_q == CNT_W'(1));

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (load && (load_val != '0)) |=> (cnt_q != '0));
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
  parameter int LIMIT_MS = 10,
  parameter int RETRY_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_ms,
  input  logic oc_raw,
  input  logic shutdown,
  output logic limit_active,
  output logic reg_enable,
  output logic fault
);
  import ocp_pkg::*;

  localparam int MAX_MS = (RETRY_MS > LIMIT_MS) ? RETRY_MS : LIMIT_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  ocp_state_t       state_q, state_d;
  logic             oc_s;
  logic             tmr_load, tmr_run, tmr_exp;
  logic [CNT_W-1:0] tmr_val;

  ocp_sync2 u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (oc_raw),
    .d_out (oc_s)
  );

  always_comb begin
    state_d = state_q;
    if (shutdown) begin
      state_d = ST_HALT;
    end else begin
      case (state_q)
        ST_RUN:   if (oc_s) state_d = ST_LIMIT;
        ST_LIMIT: if (tmr_exp) state_d = oc_s ? ST_OFF : ST_RUN;
        ST_OFF:   if (tmr_exp) state_d = ST_LIMIT;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  assign tmr_run  = (state_q == ST_LIMIT) || (state_q == ST_OFF);
  assign tmr_load = (state_d != state_q) &&
                    ((state_d == ST_LIMIT) || (state_d == ST_OFF));
  assign tmr_val  = (state_d == ST_OFF) ? CNT_W'(RETRY_MS) : CNT_W'(LIMIT_MS);

  ocp_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .tick     (tick_ms),
    .expire   (tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      limit_active <= 1'b0;
      reg_enable   <= 1'b1;
      fault        <= 1'b0;
    end else begin
      state_q      <= state_d;
      limit_active <= (state_d == ST_LIMIT);
      reg_enable   <= (state_d == ST_RUN) || (state_d == ST_LIMIT);
      fault        <= (state_d == ST_LIMIT) || (state_d == ST_OFF);
    end
  end

  // R10
  limit_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    limit_active |-> reg_enable);

  // R8
  shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!reg_enable && !fault && !limit_active));

  // R4
  off_on_persist_chk: assert property (@(posedge clk) disable iff (rst)
    (!shutdown && state_q == ST_LIMIT && tmr_exp && oc_s) |=> (!reg_enable && fault));

  // R6
  clear_on_recover_chk: assert property (@(posedge clk) disable iff (rst)
    (!shutdown && state_q == ST_LIMIT && tmr_exp && !oc_s) |=> (reg_enable && !fault));

  // R5
  retry_reenable_chk: assert property (@(posedge clk) disable iff (rst)
    (!shutdown && state_q == ST_OFF && tmr_exp) |=> (reg_enable && limit_active));
endmodule

// File: tb/tb_ocp_hiccup_ctrl.sv
module tb_ocp_hiccup_ctrl;
  localparam int LIM_P = 3;
  localparam int RET_P = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_ms = 1'b0;
  logic oc_raw = 1'b0;
  logic shutdown = 1'b0;
  logic limit_active, reg_enable, fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ocp_hiccup_ctrl #(.LIMIT_MS(LIM_P), .RETRY_MS(RET_P)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .oc_raw(oc_raw),
    .shutdown(shutdown), .limit_active(limit_active),
    .reg_enable(reg_enable), .fault(fault)
  );

  // behavioural model: 0 run, 1 limit, 2 off, 3 halted
  int m_st = 0;
  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0;

  function automatic bit exp_lim(int st); return st == 1; endfunction
  function automatic bit exp_en(int st);  return st == 0 || st == 1; endfunction
  function automatic bit exp_flt(int st); return st == 1 || st == 2; endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (shutdown) m_st = 3;
      else begin
        case (m_st)
          0: if (m_s2) begin m_st = 1; m_cnt = LIM_P; end
          1: if (tick_ms) begin
               if (m_cnt == 1) begin
                 if (m_s2) begin m_st = 2; m_cnt = RET_P; end
                 else m_st = 0;
               end else m_cnt--;
             end
          2: if (tick_ms) begin
               if (m_cnt == 1) begin m_st = 1; m_cnt = LIM_P; end
               else m_cnt--;
             end
          default: m_st = 0;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = oc_raw;
    end
  end

  task automatic check(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // continuous model comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2/R3 limit_active model", limit_active, exp_lim(m_st));
      check("R4/R5 reg_enable model", reg_enable, exp_en(m_st));
      check("R6/R7 fault model", fault, exp_flt(m_st));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_len(output int n, input bit want_lim);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      if ((want_lim ? limit_active : !reg_enable) !== 1'b1) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    cyc(1);
    // R1 reset values
    check("R1 en", reg_enable, 1'b1);
    check("R1 limit", limit_active, 1'b0);
    check("R1 fault", fault, 1'b0);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check("R1 en after release", reg_enable, 1'b1);
    tick_ms = 1'b1;
    // R9 ticks in normal operation change nothing
    cyc(20);
    check("R9 idle limit", limit_active, 1'b0);
    check("R9 idle fault", fault, 1'b0);
    // R2 synchroniser latency
    oc_raw = 1'b1;
    cyc(2);
    check("R2 not yet", limit_active, 1'b0);
    cyc(1);
    check("R2 limit", limit_active, 1'b1);
    check("R2 fault", fault, 1'b1);
    check("R2 en", reg_enable, 1'b1);
    // R3 / R9 window length unaffected by earlier ticks
    run_len(n, 1'b1);
    check("R3 R9 limit length", n == LIM_P, 1'b1);
    // R4 off state
    check("R4 en", reg_enable, 1'b0);
    check("R4 fault", fault, 1'b1);
    // R5 rest length and re-entry
    run_len(n, 1'b0);
    check("R5 rest length", n == RET_P, 1'b1);
    check("R5 relimit", limit_active, 1'b1);
    // R7 repeat cycles
    for (int k = 0; k < 3; k++) begin
      run_len(n, 1'b1);
      check("R7 limit length", n == LIM_P, 1'b1);
      run_len(n, 1'b0);
      check("R7 rest length", n == RET_P, 1'b1);
    end
    // R6 recovery: drop flag at start of a limit window
    oc_raw = 1'b0;
    run_len(n, 1'b1);
    check("R6 limit length", n == LIM_P, 1'b1);
    check("R6 fault clear", fault, 1'b0);
    check("R6 en", reg_enable, 1'b1);
    // R8 shutdown during rest
    oc_raw = 1'b1;
    cyc(3 + LIM_P + 1);
    check("R8 pre in rest", reg_enable, 1'b0);
    shutdown = 1'b1;
    cyc(1);
    check("R8 fault off", fault, 1'b0);
    check("R8 en off", reg_enable, 1'b0);
    cyc(10);
    check("R8 oc ignored limit", limit_active, 1'b0);
    check("R8 oc ignored fault", fault, 1'b0);
    oc_raw = 1'b0;
    cyc(3);
    shutdown = 1'b0;
    cyc(1);
    check("R8 release en", reg_enable, 1'b1);
    check("R8 release fault", fault, 1'b0);
    // random phase against model
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(19) == 0) oc_raw = ~oc_raw;
      tick_ms = ($urandom_range(2) == 0);
      if (shutdown) shutdown = ($urandom_range(3) != 0);
      else shutdown = ($urandom_range(299) == 0);
      cyc(1);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule